// File: doc/BRIEF.md
# Banked Pointer Register File

This block widens a 16-bit processor address into a 24-bit one. It keeps four 8-bit bank pointers, each playing one logical role: current code, data 0, data 1 and new code. The processor supplies a role select with every bus cycle. The block places the chosen pointer above the processor's low 16 address bits, so each cycle can reach any of 256 banks of 64 KB. The select may differ from one cycle to the next. This lets code fetches and data accesses within one instruction use different banks. The data 0, data 1 and new-code roles can all serve as data pointers.

Cycles flagged as stack or zero-page always go to bank 00h. The pointer contents and the select have no effect on them. Pointers are loaded from the data bus through a write port addressed by logical role. Far jumps, far calls and far returns need the current-code and new-code values to trade places. A 1-bit rename map does this by swapping which physical entries the two roles name, so no data is copied. Opcode decoding and microcode sequencing live outside the block.

Top module: `bankptr_file`

## Requirements
- R1: After reset every pointer reads 00h and the rename map is clear, so every role select yields upper address bits 00h.
- R2: `full_addr` is, combinationally in the same cycle, the 8-bit pointer of the role on `sel_role` (0 = current code, 1 = data 0, 2 = data 1, 3 = new code) in bits 23:16, with `cpu_addr` in bits 15:0.
- R3: The select can change on every cycle, and each role's value comes out independently of the roles selected before it.
- R4: While `force_bank0` is high, bits 23:16 are 00h whatever the pointers and `sel_role` hold, and bits 15:0 still follow `cpu_addr`.
- R5: A cycle with `wr_en` high loads `wr_data` into the role on `wr_role` at the clock edge, and the other roles keep their values.
- R6: An `xchg` pulse exchanges, at the clock edge, the values seen through role 0 and role 3, and leaves roles 1 and 2 unchanged. A second pulse restores the original view.
- R7: After an exchange, a write to a logical role goes to the entry that role now names. Writing role 0 changes only role 0's readout.
- R8: When `wr_en` and `xchg` are high in the same cycle, the write goes to the mapping in force before the edge and the exchange follows it. Data written to role 0 therefore reads back through role 3 afterwards.
- R9: With `wr_en` and `xchg` both low, no role's value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor's low address bits |
| sel_role | input | 2 | Logical role that drives the upper address this cycle |
| force_bank0 | input | 1 | Stack or zero-page cycle: force bank 00h |
| wr_en | input | 1 | Pointer write enable |
| wr_role | input | 2 | Logical role to write |
| wr_data | input | 8 | Value to write |
| xchg | input | 1 | Exchange the current-code and new-code roles |
| full_addr | output | 24 | Composed 24-bit address |

## Verification
Each role is loaded with a distinct value, and the select is then swept in several orders. A wrong mux index or a stale selection shows up as a mismatched bank. The zero-bank input is raised over nonzero pointers under every select. This separates forcing from an ordinary pointer that happens to be zero. Exchange is tried alone, twice in a row, followed by writes, and in the same cycle as a write. These cases tell a renaming map apart from a copy, and show whether the write uses the old or the new mapping.

// File: rtl/bankptr_pkg.sv
package bankptr_pkg;
  localparam int N_ROLE = 4;
  localparam int ROLE_W = $clog2(N_ROLE);

  typedef enum logic [ROLE_W-1:0] {
    ROLE_CODE  = 2'd0,
    ROLE_DATA0 = 2'd1,
    ROLE_DATA1 = 2'd2,
    ROLE_NEWC  = 2'd3
  } role_e;

  // Logical role to physical entry under the current rename state.
  function automatic logic [ROLE_W-1:0] map_role(input logic [ROLE_W-1:0] role,
                                                 input logic swapped);
    logic [ROLE_W-1:0] phys;
    phys = role;
    if (swapped && role == ROLE_CODE) phys = ROLE_NEWC;
    if (swapped && role == ROLE_NEWC) phys = ROLE_CODE;
    return phys;
  endfunction
endpackage

// File: rtl/bankptr_rename.sv
module bankptr_rename (
  input  logic clk,
  input  logic rst_n,
  input  logic xchg,
  output logic swapped
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    swapped <= 1'b0;
    else if (xchg) swapped <= ~swapped;
  end
endmodule

// File: rtl/bankptr_regs.sv
module bankptr_regs
  import bankptr_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ROLE_W-1:0]             wr_phys,
  input  logic [BANK_W-1:0]             wr_data,
  output logic [N_ROLE-1:0][BANK_W-1:0] ptr_q
);
  for (genvar i = 0; i < N_ROLE; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ptr_q[i] <= '0;
      else if (wr_en && wr_phys == ROLE_W'(i))
        ptr_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/bankptr_mux.sv
module bankptr_mux #(
  parameter int BANK_W = 8,
  parameter int CPU_AW = 16
) (
  input  logic [BANK_W-1:0]        bank,
  input  logic                     force_bank0,
  input  logic [CPU_AW-1:0]        cpu_addr,
  output logic [BANK_W+CPU_AW-1:0] full_addr
);
  localparam int FULL_W = BANK_W + CPU_AW;

  function automatic logic [FULL_W-1:0] compose(input logic [BANK_W-1:0] b,
                                                input logic f,
                                                input logic [CPU_AW-1:0] lo);
    return {(f ? {BANK_W{1'b0}} : b), lo};
  endfunction

  assign full_addr = compose(bank, force_bank0, cpu_addr);
endmodule

// File: rtl/bankptr_file.sv
module bankptr_file
  import bankptr_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int CPU_AW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic [ROLE_W-1:0]        sel_role,
  input  logic                     force_bank0,
  input  logic                     wr_en,
  input  logic [ROLE_W-1:0]        wr_role,
  input  logic [BANK_W-1:0]        wr_data,
  input  logic                     xchg,
  output logic [BANK_W+CPU_AW-1:0] full_addr
);
  logic                          swapped;
  logic [ROLE_W-1:0]             wr_phys;
  logic [N_ROLE-1:0][BANK_W-1:0] ptr_q;
  logic [N_ROLE-1:0][BANK_W-1:0] role_view;
  logic [BANK_W-1:0]             sel_bank;

  bankptr_rename u_rename (
    .clk     (clk),
    .rst_n   (rst_n),
    .xchg    (xchg),
    .swapped (swapped)
  );

  assign wr_phys = map_role(wr_role, swapped);

  bankptr_regs #(.BANK_W(BANK_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_phys (wr_phys),
    .wr_data (wr_data),
    .ptr_q   (ptr_q)
  );

  for (genvar r = 0; r < N_ROLE; r++) begin : g_view
    assign role_view[r] = ptr_q[map_role(ROLE_W'(r), swapped)];
  end

  assign sel_bank = role_view[sel_role];

  bankptr_mux #(.BANK_W(BANK_W), .CPU_AW(CPU_AW)) u_mux (
    .bank        (sel_bank),
    .force_bank0 (force_bank0),
    .cpu_addr    (cpu_addr),
    .full_addr   (full_addr)
  );
endmodule

// File: rtl/bankptr_file_chk.sv
module bankptr_file_chk
  import bankptr_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int CPU_AW = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [CPU_AW-1:0]             cpu_addr,
  input logic [ROLE_W-1:0]             sel_role,
  input logic                          force_bank0,
  input logic                          wr_en,
  input logic [ROLE_W-1:0]             wr_role,
  input logic [BANK_W-1:0]             wr_data,
  input logic                          xchg,
  input logic [BANK_W+CPU_AW-1:0]      full_addr,
  input logic [N_ROLE-1:0][BANK_W-1:0] role_view
);
  localparam int FULL_W = BANK_W + CPU_AW;

  p_zero_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    force_bank0 |-> full_addr[FULL_W-1:CPU_AW] == '0);

  p_low_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_addr[CPU_AW-1:0] == cpu_addr);

  p_sel_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !force_bank0 |-> full_addr[FULL_W-1:CPU_AW] == role_view[sel_role]);

  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !xchg) |=> role_view[$past(wr_role)] == $past(wr_data));

  p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg && !wr_en) |=> (role_view[ROLE_CODE] == $past(role_view[ROLE_NEWC]) &&
                          role_view[ROLE_NEWC] == $past(role_view[ROLE_CODE]) &&
                          $stable(role_view[ROLE_DATA0]) &&
                          $stable(role_view[ROLE_DATA1])));

  p_write_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && xchg && wr_role == ROLE_CODE) |=> role_view[ROLE_NEWC] == $past(wr_data));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !xchg) |=> $stable(role_view));
endmodule

bind bankptr_file bankptr_file_chk #(.BANK_W(BANK_W), .CPU_AW(CPU_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .sel_role    (sel_role),
  .force_bank0 (force_bank0),
  .wr_en       (wr_en),
  .wr_role     (wr_role),
  .wr_data     (wr_data),
  .xchg        (xchg),
  .full_addr   (full_addr),
  .role_view   (role_view)
);

// File: tb/bankptr_file_bench.sv
`timescale 1ns/1ps
module bankptr_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [1:0]  sel_role = '0;
  logic        force_bank0 = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_role = '0;
  logic [7:0]  wr_data = '0;
  logic        xchg = 1'b0;
  logic [23:0] full_addr;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [4];

  always #5 clk = ~clk;

  bankptr_file u_bankptr_file (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .sel_role(sel_role),
    .force_bank0(force_bank0), .wr_en(wr_en), .wr_role(wr_role),
    .wr_data(wr_data), .xchg(xchg), .full_addr(full_addr)
  );

  task automatic check(input string req, input logic [23:0] exp);
    checks++;
    if (full_addr !== exp) begin
      failures++;
      $display("FAIL %s sel=%0d force=%0b got=%06h exp=%06h",
               req, sel_role, force_bank0, full_addr, exp);
    end
  endtask

  // Drive a select and low address away from the edge and compare.
  task automatic look(input string req, input int role, input logic [15:0] lo,
                      input logic frc);
    sel_role = 2'(role);
    cpu_addr = lo;
    force_bank0 = frc;
    #1;
    check(req, {(frc ? 8'h00 : model[role]), lo});
  endtask

  // One clock with given write/exchange controls; model updated per R5/R8.
  task automatic step(input logic we, input int role, input logic [7:0] d,
                      input logic x);
    logic [7:0] t;
    @(negedge clk);
    wr_en = we; wr_role = 2'(role); wr_data = d; xchg = x;
    @(posedge clk);
    if (we) model[role] = d;
    if (x) begin t = model[0]; model[0] = model[3]; model[3] = t; end
    @(negedge clk);
    wr_en = 1'b0; xchg = 1'b0; wr_data = 8'h00;
  endtask

  task automatic t_reset;
    for (int r = 0; r < 4; r++) model[r] = 8'h00;
    rst_n = 1'b0;
    #3;
    look("R1", 0, 16'h1234, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 4; r++) look("R1", r, 16'hBEEF, 1'b0);
  endtask

  task automatic t_write_each;
    step(1'b1, 0, 8'h11, 1'b0);
    step(1'b1, 1, 8'h22, 1'b0);
    step(1'b1, 2, 8'h33, 1'b0);
    step(1'b1, 3, 8'h44, 1'b0);
    for (int r = 0; r < 4; r++) look("R5", r, 16'h0F0F, 1'b0);
    step(1'b1, 2, 8'hA5, 1'b0);
    for (int r = 0; r < 4; r++) look("R5", r, 16'h5A5A, 1'b0);
  endtask

  task automatic t_select_sweep;
    look("R2", 1, 16'h0000, 1'b0);
    look("R2", 1, 16'hFFFF, 1'b0);
    for (int r = 3; r >= 0; r--) look("R3", r, 16'(r * 16'h1111), 1'b0);
    look("R3", 0, 16'h8000, 1'b0);
    look("R3", 2, 16'h8001, 1'b0);
    look("R3", 0, 16'h8002, 1'b0);
  endtask

  task automatic t_force_zero;
    for (int r = 0; r < 4; r++) look("R4", r, 16'hC0DE, 1'b1);
    look("R4", 1, 16'h0100, 1'b0);
  endtask

  task automatic t_exchange;
    step(1'b0, 0, 8'h00, 1'b1);
    for (int r = 0; r < 4; r++) look("R6", r, 16'h2222, 1'b0);
    step(1'b0, 0, 8'h00, 1'b1);
    for (int r = 0; r < 4; r++) look("R6", r, 16'h3333, 1'b0);
  endtask

  task automatic t_write_after_swap;
    step(1'b0, 0, 8'h00, 1'b1);
    step(1'b1, 0, 8'h5C, 1'b0);
    for (int r = 0; r < 4; r++) look("R7", r, 16'h4444, 1'b0);
    step(1'b1, 3, 8'h6D, 1'b0);
    for (int r = 0; r < 4; r++) look("R7", r, 16'h4545, 1'b0);
  endtask

  task automatic t_write_with_swap;
    step(1'b1, 0, 8'h7E, 1'b1);
    for (int r = 0; r < 4; r++) look("R8", r, 16'h5555, 1'b0);
    step(1'b1, 3, 8'h9F, 1'b1);
    for (int r = 0; r < 4; r++) look("R8", r, 16'h5656, 1'b0);
  endtask

  task automatic t_no_write;
    @(negedge clk);
    wr_role = 2'd1; wr_data = 8'hEE; wr_en = 1'b0; xchg = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < 4; r++) look("R9", r, 16'h6666, 1'b0);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_write_each();
    t_select_sweep();
    t_force_zero();
    t_exchange();
    t_write_after_swap();
    t_write_with_swap();
    t_no_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule